// File: doc/BRIEF.md
# Self-Timed Byte-Write Controller for a Parallel Non-Volatile Memory

This block models the control logic of a byte-wide non-volatile memory that a host drives like an asynchronous static RAM. It has an active-low chip select, read strobe and write strobe, a 9-bit address and an 8-bit data path. The data path is split into an input bus, an output bus and an output-drive flag, which together stand for the bidirectional pins. The storage is a register array of 512 bytes, and an erased byte reads as all ones.

A write strobe that is long enough and not inhibited captures the address and data inside the block. From then on the host buses are free. A sequencer then steps through an erase phase and a program phase under its own cycle timer. Programming can only clear bits, so the erase step is what allows any new byte to land correctly. The host finds out that the write has finished by reading back: while the sequencer is busy, every read returns a status byte whose top bit is the inverse of the captured data's top bit. Once the write has finished, reads return the stored byte. A bulk-erase input, sampled when a write is accepted, turns that write into a timed erase of the whole array.

Sequencer states: `SEQ_IDLE`, `SEQ_ERASE`, `SEQ_PROG`, `SEQ_CLEAR`. Transitions:
- IDLE→ERASE: a byte write is accepted.
- IDLE→CLEAR: a write is accepted with bulk erase high.
- ERASE→PROG: the erase time has run out.
- PROG→IDLE: the program time has run out.
- CLEAR→IDLE: the full write time has run out.

Top module: `nvm_byte_writer`

## Requirements
- R1: Reset leaves every location at 8'hFF and the sequencer idle. A read (cs_n=0, oe_n=0, we_n=1) sets data_oe=1 and drives the addressed byte. In every other case data_oe=0 and data_out=0.
- R2: A write is accepted on the WE_MIN_CLKS-th consecutive rising clock edge at which cs_n=0, we_n=0 and oe_n=1 hold. A shorter write-strobe pulse is ignored, and one pulse is accepted at most once.
- R3: A write strobe given while oe_n=0 or cs_n=1 is ignored: the stored data does not change and the block does not become busy.
- R4: Address and data are captured at acceptance, and later changes on addr and data_in do not alter the result.
- R5: The block is busy for exactly WR_CLKS cycles after the accepting edge, where WR_CLKS is WR_SLOW_CLKS when SLOW_SEL=1 and WR_FAST_CLKS otherwise. The erase phase lasts WR_CLKS/2 cycles and the program phase takes the rest.
- R6: The addressed byte is erased to 8'hFF before programming. Because programming only clears bits, the new byte is stored exactly, whatever was there before.
- R7: While busy, a read of any address returns {~captured_data[7], 7'b0}. After completion, a read returns the stored byte.
- R8: A write that would be accepted while the block is busy is ignored.
- R9: If bulk_clr=1 at acceptance, the block stays busy for WR_CLKS cycles with captured data 8'hFF (poll bit 7 reads 0), and then every location reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| bulk_clr | input | 1 | Turns an accepted write into a whole-array erase |
| addr | input | 9 | Byte address |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data or polling status |
| data_oe | output | 1 | High when the block drives the data bus |

## Verification
A wrong sequencer state shows up in the first poll read after a write. A poll bit that flips too early or too late shows an error in the timer or the phase sequence, and the bench detects it to the exact cycle by counting polls. A missed erase step shows in the read-back after overwriting 8'h0F with 8'hF0: the byte reads 8'h00 instead of 8'hF0. A broken strobe filter or inhibit path shows at once as an unexpected busy status on the next read, or later as a changed byte.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_PROG  = 2'd2,
        SEQ_CLEAR = 2'd3
    } seq_state_e;
endpackage

// File: rtl/nvm_we_filter.sv
module nvm_we_filter #(
    parameter int MIN_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    output logic fire
);
    localparam int CW = $clog2(MIN_CLKS + 1);

    logic          wr_cond;
    logic [CW-1:0] hold_cnt;

    // write condition: selected, strobed, read strobe inactive (inhibit otherwise)
    assign wr_cond = !cs_n && !we_n && oe_n;
    assign fire    = wr_cond && (hold_cnt == CW'(MIN_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!wr_cond) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CW'(MIN_CLKS)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    AST_ONE_FIRE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R2

    AST_FIRE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (oe_n && !cs_n)); // R3
endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int ERASE_CLKS = 5000,
    parameter int PROG_CLKS  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              bulk,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              erase_cell,
    output logic              prog_cell,
    output logic              clear_all
);
    localparam int TOTAL_CLKS = ERASE_CLKS + PROG_CLKS;
    localparam int TW         = $clog2(TOTAL_CLKS + 1);

    seq_state_e    state_q, state_d;
    logic [TW-1:0] tmr;
    logic          tmr_done;

    always_comb begin
        unique case (state_q)
            SEQ_ERASE: tmr_done = (tmr == TW'(ERASE_CLKS - 1));
            SEQ_PROG:  tmr_done = (tmr == TW'(PROG_CLKS - 1));
            SEQ_CLEAR: tmr_done = (tmr == TW'(TOTAL_CLKS - 1));
            default:   tmr_done = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (fire) state_d = bulk ? SEQ_CLEAR : SEQ_ERASE;
            SEQ_ERASE: if (tmr_done) state_d = SEQ_PROG;
            SEQ_PROG:  if (tmr_done) state_d = SEQ_IDLE;
            SEQ_CLEAR: if (tmr_done) state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy       = (state_q != SEQ_IDLE);
        erase_cell = (state_q == SEQ_ERASE) && tmr_done;
        prog_cell  = (state_q == SEQ_PROG)  && tmr_done;
        clear_all  = (state_q == SEQ_CLEAR) && tmr_done;
    end

    // phase timer and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr      <= '0;
            lat_addr <= '0;
            lat_data <= '1;
        end else begin
            if (state_d != state_q || state_q == SEQ_IDLE) tmr <= '0;
            else                                          tmr <= tmr + 1'b1;
            if (state_q == SEQ_IDLE && fire) begin
                lat_addr <= addr_in;
                lat_data <= bulk ? '1 : data_in;
            end
        end
    end

    AST_BUSY_HOLDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fire) |=> ($stable(lat_addr) && $stable(lat_data))); // R8

    AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PROG) |-> ($past(state_q) == SEQ_ERASE || $past(state_q) == SEQ_PROG)); // R6

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr < TW'(TOTAL_CLKS)); // R5

    AST_CLEAR_POLL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_CLEAR) |-> (lat_data == '1)); // R9
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_cell,
    input  logic              prog_cell,
    input  logic              clear_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    assign rd_data = cells[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (clear_all) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (erase_cell) begin
            cells[wr_addr] <= '1;
        end else if (prog_cell) begin
            // programming can only clear bits
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_cell, prog_cell, clear_all})); // R9
endmodule

// File: rtl/nvm_byte_writer.sv
module nvm_byte_writer #(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int WE_MIN_CLKS  = 4,
    parameter int WR_FAST_CLKS = 10000,
    parameter int WR_SLOW_CLKS = 50000,
    parameter bit SLOW_SEL     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              bulk_clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam int WR_CLKS    = SLOW_SEL ? WR_SLOW_CLKS : WR_FAST_CLKS;
    localparam int ERASE_CLKS = WR_CLKS / 2;
    localparam int PROG_CLKS  = WR_CLKS - ERASE_CLKS;

    logic              fire, busy, erase_cell, prog_cell, clear_all, rd_act;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data, rd_data;

    nvm_we_filter #(.MIN_CLKS(WE_MIN_CLKS)) i_filter (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .fire(fire)
    );

    nvm_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ERASE_CLKS(ERASE_CLKS), .PROG_CLKS(PROG_CLKS)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .fire(fire), .bulk(bulk_clr),
        .addr_in(addr), .data_in(data_in), .busy(busy),
        .lat_addr(lat_addr), .lat_data(lat_data),
        .erase_cell(erase_cell), .prog_cell(prog_cell), .clear_all(clear_all)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n),
        .erase_cell(erase_cell), .prog_cell(prog_cell), .clear_all(clear_all),
        .wr_addr(lat_addr), .wr_data(lat_data),
        .rd_addr(addr), .rd_data(rd_data)
    );

    assign rd_act  = !cs_n && !oe_n && we_n;
    assign data_oe = rd_act;

    always_comb begin
        if (!rd_act)   data_out = '0;
        else if (busy) data_out = {~lat_data[DATA_W-1], {(DATA_W-1){1'b0}}};
        else           data_out = rd_data;
    end

    AST_QUIET_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0)); // R1

    AST_POLL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && busy) |-> (data_out[DATA_W-2:0] == '0)); // R7

    AST_ACCEPT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !busy) |=> busy); // R2
endmodule

// File: tb/test_nvm_byte_writer.sv
module test_nvm_byte_writer;
    localparam int WE_MIN = 3;
    localparam int FAST   = 20;
    localparam int SLOW   = 48;
    localparam int WR     = SLOW; // SLOW_SEL=1

    typedef struct {
        logic [7:0] exp_data;
        logic       exp_oe;
        string      tag;
    } rd_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, bulk_clr = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    rd_item_t sb_q[$];
    event rd_ev;

    always #10 clk = ~clk;

    nvm_byte_writer #(
        .WE_MIN_CLKS(WE_MIN), .WR_FAST_CLKS(FAST),
        .WR_SLOW_CLKS(SLOW), .SLOW_SEL(1'b1)
    ) i_nvm_byte_writer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .bulk_clr(bulk_clr), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads and compares
    initial begin
        forever begin
            rd_item_t it;
            @(rd_ev);
            it = sb_q.pop_front();
            chk(data_out == it.exp_data && data_oe == it.exp_oe, it.tag,
                {data_oe, data_out}, {it.exp_oe, it.exp_data});
        end
    end

    // driver: one read, expected item pushed to the scoreboard
    task automatic rd(input logic [8:0] a, input logic oe_v, input logic [7:0] exp,
                      input logic exp_oe, input string tag);
        rd_item_t it;
        @(negedge clk);
        cs_n = 1'b0; oe_n = oe_v; we_n = 1'b1; addr = a;
        it.exp_data = exp; it.exp_oe = exp_oe; it.tag = tag;
        #2;
        sb_q.push_back(it);
        -> rd_ev;
        #1;
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, input logic clr,
                      input int hold, input logic cs_v, input logic oe_v);
        @(negedge clk);
        cs_n = cs_v; oe_n = oe_v; we_n = 1'b0; addr = a; data_in = d; bulk_clr = clr;
        repeat (hold) @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1; bulk_clr = 1'b0;
        addr = ~a; data_in = ~d; // buses reused by the host (R4)
    endtask

    // poll from the current negedge until bit 7 equals done_bit; returns step count
    task automatic poll(input logic [8:0] a, input logic done_bit, output int n);
        cs_n = 1'b0; oe_n = 1'b0; addr = a;
        n = 0;
        #2;
        while (data_out[7] !== done_bit && n < 1000) begin
            @(negedge clk);
            #2;
            n++;
        end
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and read-enable gating
        rd(9'h000, 1'b0, 8'hFF, 1'b1, "R1 reset content addr 0");
        rd(9'h1FF, 1'b0, 8'hFF, 1'b1, "R1 reset content addr 1FF");
        rd(9'h000, 1'b1, 8'h00, 1'b0, "R1 no drive with oe_n high");

        // R2 R5 R7 accepted write, exact busy length, poll status
        wr(9'h000, 8'h5A, 1'b0, WE_MIN, 1'b0, 1'b1);
        cs_n = 1'b0; oe_n = 1'b0; addr = 9'h000; #2;
        chk(data_out == 8'h80, "R7 poll byte while busy", data_out, 8'h80);
        poll(9'h000, 1'b0, n);
        chk(n == WR, "R5 busy length", n, WR);
        rd(9'h000, 1'b0, 8'h5A, 1'b1, "R4 R7 read-back after write");
        rd(9'h001, 1'b0, 8'hFF, 1'b1, "R4 neighbour untouched");

        // R6 overwrite requires erase
        wr(9'h1FF, 8'h0F, 1'b0, WE_MIN, 1'b0, 1'b1);
        poll(9'h1FF, 1'b0, n);
        wr(9'h1FF, 8'hF0, 1'b0, WE_MIN + 2, 1'b0, 1'b1);
        poll(9'h1FF, 1'b1, n);
        rd(9'h1FF, 1'b0, 8'hF0, 1'b1, "R6 overwrite 0F with F0");

        // R2 short pulse ignored
        wr(9'h000, 8'h00, 1'b0, WE_MIN - 1, 1'b0, 1'b1);
        rd(9'h000, 1'b0, 8'h5A, 1'b1, "R2 short pulse not busy");
        repeat (WR + 4) @(negedge clk);
        rd(9'h000, 1'b0, 8'h5A, 1'b1, "R2 short pulse no change");

        // R3 inhibit by read strobe and by deselect
        wr(9'h002, 8'h33, 1'b0, WE_MIN + 2, 1'b0, 1'b0);
        rd(9'h002, 1'b0, 8'hFF, 1'b1, "R3 inhibit oe_n low");
        wr(9'h002, 8'h33, 1'b0, WE_MIN + 2, 1'b1, 1'b1);
        rd(9'h002, 1'b0, 8'hFF, 1'b1, "R3 inhibit cs_n high");
        repeat (WR + 4) @(negedge clk);
        rd(9'h002, 1'b0, 8'hFF, 1'b1, "R3 inhibit no later change");

        // R8 write during busy ignored; R7 poll at another address
        wr(9'h005, 8'h11, 1'b0, WE_MIN, 1'b0, 1'b1);
        wr(9'h006, 8'h22, 1'b0, WE_MIN, 1'b0, 1'b1);
        rd(9'h100, 1'b0, 8'h80, 1'b1, "R7 poll at other address");
        @(negedge clk);
        poll(9'h005, 1'b0, n);
        rd(9'h005, 1'b0, 8'h11, 1'b1, "R8 first write stored");
        repeat (WR + 4) @(negedge clk);
        rd(9'h006, 1'b0, 8'hFF, 1'b1, "R8 busy write dropped");

        // R9 whole-array erase
        wr(9'h000, 8'h00, 1'b1, WE_MIN, 1'b0, 1'b1);
        cs_n = 1'b0; oe_n = 1'b0; addr = 9'h005; #2;
        chk(data_out == 8'h00, "R9 clear poll byte", data_out, 8'h00);
        poll(9'h005, 1'b1, n);
        chk(n == WR, "R9 clear busy length", n, WR);
        rd(9'h000, 1'b0, 8'hFF, 1'b1, "R9 cleared addr 0");
        rd(9'h005, 1'b0, 8'hFF, 1'b1, "R9 cleared addr 5");
        rd(9'h1FF, 1'b0, 8'hFF, 1'b1, "R9 cleared addr 1FF");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule